// File: doc/BRIEF.md
# Burst SPI Master with Lead, Lag and Inter-Frame Spacing

This block is an SPI master that moves a burst of 8-bit frames in a single transaction. Chip select stays low for the whole burst. SCK idles low and runs in mode 0: MOSI is launched while SCK is low, and MISO is captured on the rising edge, most significant bit first. The SCK half-period is set by an even divisor of the system clock.

Three programmable spacings, each counted in system-clock cycles, shape the transaction:

- The lead spacing runs from chip select falling to the first SCK rising edge.
- The inter-frame spacing stretches the low time of SCK between two frames.
- The lag spacing runs from the final SCK falling edge to chip select rising.

A spacing of zero adds nothing beyond one normal half-period. The last bit of every frame therefore always keeps a full-width high phase, even when frames are packed back to back.

Outgoing bytes arrive over a valid/ready handshake. If the next byte is late, the master parks with SCK low and chip select asserted until the byte is offered. Each received byte is presented with a one-cycle strobe. A one-cycle completion pulse marks the release of chip select. All settings are captured when a transaction starts.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, cs_n_o is 1, and sck_o, mosi_o, done_o, rx_valid_o and tx_ready_o are 0.
- R2: A start_i pulse has no effect in either of two cases: nframes_i is 0, or a transaction is already in progress. In both cases the frame count and timing of the current or idle state are unchanged.
- R3: Let H = max(floor(div_i/2), 1). Within a frame, each SCK high phase and each SCK low phase lasts exactly H cycles. MOSI carries the byte MSB first and changes only while SCK is low.
- R4: When the first byte is already valid, the first SCK rising edge comes exactly H + lead_i cycles after cs_n_o falls.
- R5: The last bit of each frame keeps a full H-cycle high phase. The SCK low time from the end of one frame to the first rising edge of the next is exactly H + gap_i cycles, with 0 giving exactly H. A value of 200 at a 200 MHz clock therefore adds a 1 µs low interval.
- R6: cs_n_o rises exactly H + lag_i cycles after the final SCK falling edge.
- R7: A transaction of N frames produces exactly 8·N SCK rising edges. cs_n_o falls once and rises once per transaction. SCK is low whenever cs_n_o is high.
- R8: A byte is taken on a clock edge where tx_valid_i and tx_ready_o are both 1. If no byte is valid when one is needed, SCK stays low with cs_n_o low. The frame's first rising edge then comes H cycles after the accepting edge.
- R9: rx_valid_o pulses for one cycle, in the same cycle that SCK falls at the end of each frame. rx_data_o then holds the 8 MISO bits sampled at that frame's rising edges, first sample in bit 7.
- R10: done_o pulses for exactly one cycle, in the same cycle that cs_n_o returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transaction (sampled when idle) |
| nframes_i | input | LEN_W | Number of bytes in the transaction |
| div_i | input | DIV_W | SCK divisor; half-period is div_i/2 cycles, minimum 1 |
| lead_i | input | CNT_W | Extra cycles from chip select low to first SCK edge |
| gap_i | input | CNT_W | Extra SCK-low cycles between frames |
| lag_i | input | CNT_W | Extra cycles from last SCK edge to chip select high |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_ready_o | output | 1 | Master takes the byte at the next edge if valid |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Active-low chip select |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| done_o | output | 1 | One-cycle pulse at chip select release |

## Verification
The bench exercises a seven-byte burst at the fastest divisor with no inter-frame spacing. A design that ended a frame early would show a shortened final high phase, and one that added a cycle would miss the exact H low time.

It stalls the byte stream both before the first frame and between frames. A master that ran SCK without data, or that dropped chip select while waiting, would emit the wrong edge count or a second chip-select fall.

It also pulses start with a zero frame count and again mid-transaction. A master that honoured either pulse would assert chip select from idle or clock extra frames. Finally, it measures the lead, gap and lag distances at several divisors, including the odd divisor 3 and a zero divisor, where an off-by-one in the half-period or delay counters shows up directly as a timing miscompare.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int FRAME_W = 8;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_WAIT,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LAG
    } xfer_state_e;
endpackage

// File: rtl/spi_dn_timer.sv
module spi_dn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         clear_i,
    input  logic         miso_i,
    output logic         mosi_o,
    output logic [W-1:0] rx_o
);
    logic [W-1:0] tx_d, tx_q;
    logic [W-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (clear_i) begin
            tx_d = '0;
            rx_d = '0;
        end else begin
            if (load_i) begin
                tx_d = data_i;
            end else if (shift_i) begin
                tx_d = {tx_q[W-2:0], 1'b0};
            end
            if (sample_i) begin
                rx_d = {rx_q[W-2:0], miso_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign mosi_o = tx_q[W-1];
    assign rx_o   = rx_q;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   nframes_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [CNT_W-1:0]   lead_i,
    input  logic [CNT_W-1:0]   gap_i,
    input  logic [CNT_W-1:0]   lag_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    input  logic               tx_valid_i,
    output logic               tx_ready_o,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               cs_n_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               rx_valid_o,
    output logic               done_o
);
    // Delay timer must hold any CNT_W value plus one half-period.
    localparam int TMR_W = ((CNT_W > DIV_W) ? CNT_W : DIV_W) + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        xfer_state_e        state;
        logic               sck;
        logic               cs_n;
        logic               rx_valid;
        logic               done;
        logic [FRAME_W-1:0] rx_data;
        logic [DIV_W-1:0]   half;
        logic [CNT_W-1:0]   gap;
        logic [CNT_W-1:0]   lag;
        logic [LEN_W-1:0]   frames;
        logic [BIT_W-1:0]   bit_idx;
    } regs_t;

    regs_t d, q;

    logic               tmr_load, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic               bt_load, bt_zero;
    logic [DIV_W-1:0]   bt_val;
    logic               sh_load, sh_shift, sh_sample, sh_clear;
    logic [FRAME_W-1:0] sh_rx;
    logic               slot;
    logic [DIV_W-1:0]   div_half, half_start, half_now;
    logic [DIV_W-1:0]   half_cur;

    assign div_half   = div_i >> 1;
    assign half_start = (div_half == '0) ? DIV_W'(1) : div_half;
    assign half_cur   = q.half;

    always_comb begin
        d           = q;
        d.rx_valid  = 1'b0;
        d.done      = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        bt_load     = 1'b0;
        bt_val      = '0;
        sh_load     = 1'b0;
        sh_shift    = 1'b0;
        sh_sample   = 1'b0;
        sh_clear    = 1'b0;
        slot        = 1'b0;
        half_now    = (q.state == ST_IDLE) ? half_start : q.half;

        case (q.state)
            ST_IDLE: begin
                if (start_i && (nframes_i != '0)) begin
                    d.cs_n   = 1'b0;
                    d.half   = half_start;
                    d.gap    = gap_i;
                    d.lag    = lag_i;
                    d.frames = nframes_i;
                    if (lead_i == '0) begin
                        slot = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(lead_i) - TMR_W'(1);
                        d.state  = ST_LEAD;
                    end
                end
            end
            ST_LEAD, ST_GAP: begin
                if (tmr_zero) begin
                    slot = 1'b1;
                end
            end
            ST_WAIT: begin
                slot = 1'b1;
            end
            ST_LOW: begin
                if (bt_zero) begin
                    d.sck     = 1'b1;
                    sh_sample = 1'b1;
                    bt_load   = 1'b1;
                    bt_val    = q.half - DIV_W'(1);
                    d.state   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (bt_zero) begin
                    d.sck = 1'b0;
                    if (q.bit_idx == LAST_BIT) begin
                        d.rx_valid = 1'b1;
                        d.rx_data  = sh_rx;
                        d.frames   = q.frames - LEN_W'(1);
                        if (q.frames == LEN_W'(1)) begin
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(q.lag) + TMR_W'(q.half) - TMR_W'(1);
                            d.state  = ST_LAG;
                        end else if (q.gap == '0) begin
                            slot = 1'b1;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(q.gap) - TMR_W'(1);
                            d.state  = ST_GAP;
                        end
                    end else begin
                        sh_shift  = 1'b1;
                        d.bit_idx = q.bit_idx + BIT_W'(1);
                        bt_load   = 1'b1;
                        bt_val    = q.half - DIV_W'(1);
                        d.state   = ST_LOW;
                    end
                end
            end
            ST_LAG: begin
                if (tmr_zero) begin
                    d.cs_n   = 1'b1;
                    d.done   = 1'b1;
                    sh_clear = 1'b1;
                    d.state  = ST_IDLE;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase

        // A byte slot: take the byte now or park with SCK low.
        if (slot) begin
            if (tx_valid_i) begin
                sh_load   = 1'b1;
                bt_load   = 1'b1;
                bt_val    = half_now - DIV_W'(1);
                d.bit_idx = '0;
                d.state   = ST_LOW;
            end else begin
                d.state = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    spi_dn_timer #(.W(TMR_W)) u_gap_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    spi_dn_timer #(.W(DIV_W)) u_bit_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bt_load),
        .val_i  (bt_val),
        .zero_o (bt_zero)
    );

    spi_byte_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (sh_load),
        .data_i   (tx_data_i),
        .shift_i  (sh_shift),
        .sample_i (sh_sample),
        .clear_i  (sh_clear),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (sh_rx)
    );

    assign tx_ready_o = slot;
    assign sck_o      = q.sck;
    assign cs_n_o     = q.cs_n;
    assign rx_data_o  = q.rx_data;
    assign rx_valid_o = q.rx_valid;
    assign done_o     = q.done;
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck_o,
    input logic             cs_n_o,
    input logic             mosi_o,
    input logic             done_o,
    input logic             rx_valid_o,
    input logic [DIV_W-1:0] half_cur
);
    logic [DIV_W:0] hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q <= '0;
        end else if (sck_o) begin
            hi_len_q <= hi_len_q + 1'b1;
        end else begin
            hi_len_q <= '0;
        end
    end

    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> (hi_len_q == {1'b0, half_cur}));

    p_rx_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $fell(sck_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $rose(cs_n_o)));
endmodule

bind spi_burst_master spi_burst_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_o      (sck_o),
    .cs_n_o     (cs_n_o),
    .mosi_o     (mosi_o),
    .done_o     (done_o),
    .rx_valid_o (rx_valid_o),
    .half_cur   (half_cur)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/100ps
module spi_burst_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  nframes = '0;
    logic [7:0]  div = 8'd4;
    logic [15:0] lead = '0, gap = '0, lag = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        miso = 1'b0;
    logic        sck, mosi, cs_n, rx_valid, done;
    logic [7:0]  rx_data;

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;

    // feeder state
    logic [7:0] tx_mem [0:7];
    logic [7:0] sl_mem [0:7];
    int idx = 0, feed_n = 0, hold_idx = -1, hold_at = 0;
    bit feed_on = 0, took = 0;

    // monitor state
    int rise_t [0:63];
    int fall_t [0:63];
    bit mosi_cap [0:63];
    logic [7:0] rx_cap [0:7];
    int rx_t [0:7];
    int nrise, nfall, nrx, csf_cnt, csr_cnt, t_csf, t_csr, done_cnt, done_t;
    int bad_sck, bad_mosi, sb_idx, sbit;
    logic sck_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .nframes_i(nframes),
        .div_i(div), .lead_i(lead), .gap_i(gap), .lag_i(lag),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .cs_n_o(cs_n),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .done_o(done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    // Byte source on the valid/ready handshake
    initial begin
        forever begin
            @(negedge clk);
            if (took) idx++;
            tx_valid = feed_on && (idx < feed_n) && !(idx == hold_idx && cyc < hold_at);
            tx_data  = tx_mem[(idx < 8) ? idx : 0];
            #1;
            took = tx_valid && tx_ready;
        end
    end

    // Edge monitor and mode-0 slave model
    always @(negedge clk) begin
        if (cs_p && !cs_n) begin
            csf_cnt++; t_csf = cyc;
            sb_idx = 0; sbit = 0; miso = sl_mem[0][7];
        end
        if (!cs_p && cs_n) begin
            csr_cnt++; t_csr = cyc;
        end
        if (!sck_p && sck) begin
            if (cs_n) bad_sck++;
            if (nrise < 64) begin
                rise_t[nrise] = cyc; mosi_cap[nrise] = mosi;
            end
            nrise++;
        end
        if (sck_p && !sck) begin
            if (nfall < 64) fall_t[nfall] = cyc;
            nfall++;
            if (!cs_n) begin
                sbit++;
                if (sbit == 8) begin sbit = 0; sb_idx++; end
                miso = sl_mem[(sb_idx < 8) ? sb_idx : 0][7 - sbit];
            end
        end
        if (sck && sck_p && mosi != mosi_p) bad_mosi++;
        if (cs_n && sck) bad_sck++;
        if (rx_valid && nrx < 8) begin
            rx_cap[nrx] = rx_data; rx_t[nrx] = cyc; nrx++;
        end
        if (done) begin done_cnt++; done_t = cyc; end
        sck_p = sck; cs_p = cs_n; mosi_p = mosi;
    end

    task automatic setup(input int nf, input int dv, input int ld, input int gp,
                         input int lg, input int hidx, input int hoff, input int seed);
        @(negedge clk);
        div = 8'(dv); lead = 16'(ld); gap = 16'(gp); lag = 16'(lg);
        for (int k = 0; k < 8; k++) begin
            tx_mem[k] = 8'(8'hA5 ^ (k * 37 + seed));
            sl_mem[k] = 8'(8'h3C + k * 29 + seed * 3);
        end
        feed_n = nf; idx = 0; took = 0; feed_on = 1;
        hold_idx = hidx; hold_at = cyc + 2 + hoff;
        nrise = 0; nfall = 0; nrx = 0; csf_cnt = 0; csr_cnt = 0;
        done_cnt = 0; bad_sck = 0; bad_mosi = 0; t_csf = 0; t_csr = 0; done_t = 0;
    endtask

    task automatic pulse_start(input int nf);
        @(negedge clk);
        start = 1'b1; nframes = 8'(nf);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (done_cnt == 0 && w < 20000) begin
            @(negedge clk); w++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input int nf, input int h, input int ld, input int gp,
                          input int lg, input int hidx);
        int exp;
        logic [7:0] b;
        chk(csf_cnt == 1, "R7 single cs fall", csf_cnt, 1);
        chk(csr_cnt == 1, "R7 single cs rise", csr_cnt, 1);
        chk(nrise == 8 * nf, "R7 rising edge count", nrise, 8 * nf);
        chk(bad_sck == 0, "R7 sck low while cs high", bad_sck, 0);
        chk(bad_mosi == 0, "R3 mosi stable while sck high", bad_mosi, 0);
        if (nrise != 8 * nf) return;
        for (int i = 0; i < nf; i++) begin
            if (hidx == i) exp = hold_at + 1 + h;
            else if (i == 0) exp = t_csf + ld + h;
            else exp = fall_t[8 * i - 1] + gp + h;
            if (hidx == i) chk(rise_t[8 * i] == exp, "R8 stalled frame first rise", rise_t[8 * i], exp);
            else if (i == 0) chk(rise_t[0] == exp, "R4 lead timing", rise_t[0], exp);
            else chk(rise_t[8 * i] == exp, "R5 inter-frame low time", rise_t[8 * i], exp);
            for (int j = 0; j < 8; j++) begin
                chk(fall_t[8 * i + j] - rise_t[8 * i + j] == h, "R5 R3 high phase width",
                    fall_t[8 * i + j] - rise_t[8 * i + j], h);
                if (j > 0)
                    chk(rise_t[8 * i + j] - fall_t[8 * i + j - 1] == h, "R3 low phase width",
                        rise_t[8 * i + j] - fall_t[8 * i + j - 1], h);
            end
            b = '0;
            for (int j = 0; j < 8; j++) b = {b[6:0], mosi_cap[8 * i + j]};
            chk(b == tx_mem[i], "R3 mosi byte msb first", b, tx_mem[i]);
            chk(rx_cap[i] == sl_mem[i], "R9 rx byte", rx_cap[i], sl_mem[i]);
            chk(rx_t[i] == fall_t[8 * i + 7], "R9 rx strobe at frame end", rx_t[i], fall_t[8 * i + 7]);
        end
        chk(nrx == nf, "R9 rx strobe count", nrx, nf);
        chk(t_csr - fall_t[8 * nf - 1] == h + lg, "R6 lag timing", t_csr - fall_t[8 * nf - 1], h + lg);
        chk(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
        chk(done_t == t_csr, "R10 done with cs release", done_t, t_csr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(sck == 1'b0, "R1 sck after reset", sck, 0);
        chk(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
        chk(done == 1'b0 && rx_valid == 1'b0, "R1 strobes after reset", done | rx_valid, 0);
        chk(tx_ready == 1'b0, "R1 tx_ready after reset", tx_ready, 0);
    endtask

    task automatic t_run(input int nf, input int dv, input int ld, input int gp,
                         input int lg, input int hidx, input int hoff, input int seed);
        int h;
        h = (dv / 2 == 0) ? 1 : dv / 2;
        setup(nf, dv, ld, gp, lg, hidx, hoff, seed);
        pulse_start(nf);
        wait_done();
        verify(nf, h, ld, gp, lg, hidx);
    endtask

    task automatic t_zero_count();
        setup(0, 4, 0, 0, 0, -1, 0, 9);
        pulse_start(0);
        repeat (20) @(negedge clk);
        chk(csf_cnt == 0, "R2 zero count ignored", csf_cnt, 0);
        chk(cs_n == 1'b1 && nrise == 0, "R2 zero count no clock", nrise, 0);
    endtask

    task automatic t_busy_start();
        setup(2, 8, 5, 1, 2, -1, 0, 11);
        pulse_start(2);
        repeat (6) @(negedge clk);
        lead = 16'd0; div = 8'd2;
        start = 1'b1; nframes = 8'd5;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        verify(2, 4, 5, 1, 2, -1);
        chk(nrise == 16, "R2 start while busy ignored", nrise, 16);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run(3, 4, 0, 0, 0, -1, 0, 1);       // basic, packed frames
        t_run(7, 2, 3, 0, 5, -1, 0, 2);       // seven bytes, fastest clock, zero gap
        t_run(2, 6, 1, 200, 0, -1, 0, 3);     // 1 us inter-frame spacing
        t_run(3, 4, 0, 2, 1, 1, 40, 4);       // stall before second byte
        t_run(1, 3, 0, 0, 0, 0, 10, 5);       // stall before first byte, odd divisor
        t_run(2, 0, 2, 3, 4, -1, 0, 6);       // zero divisor clamps to H=1
        t_zero_count();
        t_busy_start();
        summary();
    end
endmodule